// File: doc/BRIEF.md
# Interrupt IN Complete-Split Response Handler

This block sits on the host side of a split interrupt IN transfer. It handles one complete-split phase. Each complete-split attempt returns a decoded response: a packet identifier, a CRC verdict and a timeout flag. The block turns that response into one action for the scheduler. The possible actions are: move to the next command, issue another complete-split, go back to the start-split, retry the complete-split at once, or halt the endpoint. At the same time it tells the receive buffer whether to keep or drop the data of that attempt.

A transfer may arrive in two pieces. A partial-data packet (MDATA) carries the first piece and a final DATA0/DATA1 packet carries the second. The block keeps a count of pieces already handed to the buffer. Any later failure of the transfer discards those pieces through the reject strobe. A per-command error counter gives each command three strikes before the endpoint is halted. Loading a new command clears both the error counter and the piece count.

Top module: `split_cs_handler`

## Requirements
- R1: Each cycle with `rsp_valid` high produces exactly one cycle of `act_valid` high in the following cycle. `act_code` then carries the action: 0 next command, 1 next complete-split, 2 start again, 3 immediate retry, 4 halt. Without a response, `act_valid` stays low.
- R2: A NYET response (PID 4'b0110) with `last_cs` low gives action 1 and raises no strobe.
- R3: A NAK response (4'b1010) gives action 2. A STALL response (4'b1110) gives action 4.
- R4: DATA0 (4'b0011) or DATA1 (4'b1011) with a good CRC gives action 0, provided the received toggle (0 for DATA0, 1 for DATA1) equals `cmd_toggle`. The same cycle raises `acc_strobe` and `acc_final` together.
- R5: DATA0/DATA1 with a good CRC but a toggle different from `cmd_toggle` gives action 2 and raises `rej_strobe` without `acc_strobe`.
- R6: MDATA (4'b1111) with a good CRC, `last_cs` low and no piece held gives action 1. It raises `acc_strobe` with `acc_final` low, and the block then holds one piece.
- R7: Each of the following is an error attempt:
  - a bad CRC on MDATA or DATA0/DATA1;
  - an ERR handshake (4'b1100);
  - any other PID value;
  - NYET with `last_cs` high;
  - MDATA with `last_cs` high;
  - MDATA while a piece is already held.
- R8: The first and second error attempts after a command load give action 3. The third and every later one give action 4.
- R9: An error attempt, NAK or STALL while a piece is held raises `rej_strobe`. The held piece count then returns to zero.
- R10: A pulse on `cmd_load` clears the error count and the held piece count, and latches `cmd_toggle` as the expected toggle.
- R11: A response with `rsp_timeout` high is an error attempt whatever its PID. It never raises `acc_strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Start of a new command; clears counters |
| cmd_toggle | input | 1 | Expected data toggle of the new command |
| rsp_valid | input | 1 | One complete-split response is present |
| rsp_pid | input | 4 | Decoded response packet identifier |
| rsp_crc_ok | input | 1 | CRC of the data packet passed |
| rsp_timeout | input | 1 | No response arrived in time |
| last_cs | input | 1 | This is the last scheduled complete-split |
| act_valid | output | 1 | Action pulse, one cycle per response |
| act_code | output | 3 | Encoded action |
| acc_strobe | output | 1 | Keep the data of this attempt |
| acc_final | output | 1 | Kept data completes the transfer |
| rej_strobe | output | 1 | Drop the data of this transfer |

## Verification
The bench aims at the interplay of partial data and failure. It covers:
- an ERR, NAK, STALL or timeout that arrives after an accepted MDATA, where a design that forgot the held piece would leave stale data in the buffer with no reject;
- a second MDATA and an MDATA on the last slot, which a lax decoder would accept as more data;
- a run of errors across the third strike, where an off-by-one counter would retry once too often or halt one attempt early;
- a command load between errors, where a counter that is not cleared would halt at once;
- a toggle mismatch, which must drop the data rather than finish the command.

// File: rtl/split_cs_pkg.sv
package split_cs_pkg;

  typedef enum logic [3:0] {
    PID_DATA0 = 4'b0011,
    PID_DATA1 = 4'b1011,
    PID_MDATA = 4'b1111,
    PID_NAK   = 4'b1010,
    PID_STALL = 4'b1110,
    PID_NYET  = 4'b0110,
    PID_ERR   = 4'b1100
  } pid_e;

  typedef enum logic [2:0] {
    ACT_NEXT_CMD = 3'd0,
    ACT_NEXT_CS  = 3'd1,
    ACT_START    = 3'd2,
    ACT_RETRY    = 3'd3,
    ACT_HALT     = 3'd4
  } act_e;

  typedef enum logic [2:0] {
    OUT_ERROR,
    OUT_MORE,
    OUT_RESTART,
    OUT_STOP,
    OUT_DONE,
    OUT_PIECE,
    OUT_MISMATCH
  } outcome_e;

endpackage

// File: rtl/split_cs_classify.sv
module split_cs_classify
  import split_cs_pkg::*;
(
  input  logic [3:0] pid,
  input  logic       crc_ok,
  input  logic       timeout,
  input  logic       last_slot,
  input  logic       exp_toggle,
  input  logic       piece_full,
  output outcome_e   outcome
);

  logic rx_toggle;
  assign rx_toggle = pid[3];

  always_comb begin
    outcome = OUT_ERROR;
    if (!timeout) begin
      case (pid)
        PID_NYET:  outcome = last_slot ? OUT_ERROR : OUT_MORE;
        PID_NAK:   outcome = OUT_RESTART;
        PID_STALL: outcome = OUT_STOP;
        PID_DATA0,
        PID_DATA1: begin
          if (!crc_ok)                      outcome = OUT_ERROR;
          else if (rx_toggle == exp_toggle) outcome = OUT_DONE;
          else                              outcome = OUT_MISMATCH;
        end
        PID_MDATA: begin
          if (!crc_ok || last_slot || piece_full) outcome = OUT_ERROR;
          else                                    outcome = OUT_PIECE;
        end
        default:   outcome = OUT_ERROR;
      endcase
    end
  end

endmodule

// File: rtl/split_cs_errcnt.sv
module split_cs_errcnt #(
  parameter int LIMIT = 3,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);

  logic [W-1:0] cnt;
  logic [W:0]   inc;

  assign inc       = {1'b0, cnt} + (W + 1)'(1);
  assign exhausted = inc >= (W + 1)'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (bump && inc <= (W + 1)'(LIMIT)) begin
      cnt <= inc[W-1:0];
    end
  end

endmodule

// File: rtl/split_cs_pieces.sv
module split_cs_pieces #(
  parameter int MAX_PIECES = 1,
  localparam int PW        = $clog2(MAX_PIECES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic add,
  output logic held,
  output logic full
);

  logic [PW-1:0] cnt;

  assign held = cnt != '0;
  assign full = cnt == PW'(MAX_PIECES);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (add && !full) begin
      cnt <= cnt + PW'(1);
    end
  end

endmodule

// File: rtl/split_cs_handler.sv
module split_cs_handler
  import split_cs_pkg::*;
#(
  parameter int ERR_LIMIT  = 3,
  parameter int MAX_PIECES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_load,
  input  logic       cmd_toggle,
  input  logic       rsp_valid,
  input  logic [3:0] rsp_pid,
  input  logic       rsp_crc_ok,
  input  logic       rsp_timeout,
  input  logic       last_cs,
  output logic       act_valid,
  output logic [2:0] act_code,
  output logic       acc_strobe,
  output logic       acc_final,
  output logic       rej_strobe
);

  logic     exp_toggle;
  logic     piece_held;
  logic     piece_full;
  logic     err_exhausted;
  outcome_e outcome;

  logic     is_err;
  logic     drop_pieces;
  act_e     act_d;
  logic     acc_d;
  logic     fin_d;
  logic     rej_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_toggle <= 1'b0;
    end else if (cmd_load) begin
      exp_toggle <= cmd_toggle;
    end
  end

  split_cs_classify u_classify (
    .pid        (rsp_pid),
    .crc_ok     (rsp_crc_ok),
    .timeout    (rsp_timeout),
    .last_slot  (last_cs),
    .exp_toggle (exp_toggle),
    .piece_full (piece_full),
    .outcome    (outcome)
  );

  assign is_err      = rsp_valid && outcome == OUT_ERROR;
  assign drop_pieces = rsp_valid && outcome != OUT_PIECE && outcome != OUT_MORE;

  split_cs_errcnt #(.LIMIT(ERR_LIMIT)) u_errcnt (
    .clk       (clk),
    .rst       (rst),
    .clear     (cmd_load),
    .bump      (is_err),
    .exhausted (err_exhausted)
  );

  split_cs_pieces #(.MAX_PIECES(MAX_PIECES)) u_pieces (
    .clk   (clk),
    .rst   (rst),
    .clear (cmd_load || drop_pieces),
    .add   (rsp_valid && outcome == OUT_PIECE),
    .held  (piece_held),
    .full  (piece_full)
  );

  always_comb begin
    act_d = ACT_RETRY;
    acc_d = 1'b0;
    fin_d = 1'b0;
    rej_d = 1'b0;
    case (outcome)
      OUT_MORE:     act_d = ACT_NEXT_CS;
      OUT_RESTART: begin
        act_d = ACT_START;
        rej_d = piece_held;
      end
      OUT_STOP: begin
        act_d = ACT_HALT;
        rej_d = piece_held;
      end
      OUT_DONE: begin
        act_d = ACT_NEXT_CMD;
        acc_d = 1'b1;
        fin_d = 1'b1;
      end
      OUT_PIECE: begin
        act_d = ACT_NEXT_CS;
        acc_d = 1'b1;
      end
      OUT_MISMATCH: begin
        act_d = ACT_START;
        rej_d = 1'b1;
      end
      default: begin
        act_d = err_exhausted ? ACT_HALT : ACT_RETRY;
        rej_d = piece_held;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid  <= 1'b0;
      act_code   <= 3'd0;
      acc_strobe <= 1'b0;
      acc_final  <= 1'b0;
      rej_strobe <= 1'b0;
    end else begin
      act_valid  <= rsp_valid;
      act_code   <= rsp_valid ? act_d : 3'd0;
      acc_strobe <= rsp_valid && acc_d;
      acc_final  <= rsp_valid && fin_d;
      rej_strobe <= rsp_valid && rej_d;
    end
  end

endmodule

// File: rtl/split_cs_handler_chk.sv
module split_cs_handler_chk
  import split_cs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       rsp_valid,
  input logic [3:0] rsp_pid,
  input logic       rsp_timeout,
  input logic       last_cs,
  input logic       act_valid,
  input logic [2:0] act_code,
  input logic       acc_strobe,
  input logic       acc_final,
  input logic       rej_strobe
);

  a_r1_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> act_valid);

  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> !act_valid && !acc_strobe && !rej_strobe);

  a_r1_code: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> act_code <= 3'd4);

  a_r2_nyet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_timeout && rsp_pid == PID_NYET && !last_cs
    |=> act_code == ACT_NEXT_CS && !acc_strobe && !rej_strobe);

  a_r3_stall: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_timeout && rsp_pid == PID_STALL |=> act_code == ACT_HALT);

  a_r3_nak: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_timeout && rsp_pid == PID_NAK |=> act_code == ACT_START);

  a_r4_final: assert property (@(posedge clk) disable iff (rst)
    acc_final |-> acc_strobe && act_code == ACT_NEXT_CMD);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acc_strobe && rej_strobe));

  a_r11_timeout: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_timeout |=> !acc_strobe);

endmodule

bind split_cs_handler split_cs_handler_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rsp_valid   (rsp_valid),
  .rsp_pid     (rsp_pid),
  .rsp_timeout (rsp_timeout),
  .last_cs     (last_cs),
  .act_valid   (act_valid),
  .act_code    (act_code),
  .acc_strobe  (acc_strobe),
  .acc_final   (acc_final),
  .rej_strobe  (rej_strobe)
);

// File: tb/split_cs_handler_test.sv
module split_cs_handler_test;

  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011, P_MD = 4'b1111;
  localparam logic [3:0] P_NAK = 4'b1010, P_STALL = 4'b1110;
  localparam logic [3:0] P_NYET = 4'b0110, P_ERR = 4'b1100, P_BAD = 4'b0001;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_load = 1'b0, cmd_toggle = 1'b0;
  logic       rsp_valid = 1'b0, rsp_crc_ok = 1'b0, rsp_timeout = 1'b0, last_cs = 1'b0;
  logic [3:0] rsp_pid = 4'd0;
  logic       act_valid, acc_strobe, acc_final, rej_strobe;
  logic [2:0] act_code;

  int checks = 0;
  int errors = 0;
  int m_err  = 0;
  int m_held = 0;
  logic m_tog = 1'b0;

  always #10 clk = ~clk;

  split_cs_handler uut (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_toggle(cmd_toggle),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_crc_ok(rsp_crc_ok),
    .rsp_timeout(rsp_timeout), .last_cs(last_cs), .act_valid(act_valid),
    .act_code(act_code), .acc_strobe(acc_strobe), .acc_final(acc_final),
    .rej_strobe(rej_strobe)
  );

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got v/code/acc/fin/rej=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic load(logic t);
    @(negedge clk);
    cmd_load = 1'b1; cmd_toggle = t;
    @(negedge clk);
    cmd_load = 1'b0;
    m_err = 0; m_held = 0; m_tog = t;
  endtask

  // Reference expectation from the requirements: {valid, code, acc, fin, rej}
  task automatic send(string tag, logic [3:0] pid, logic crc, logic to, logic last);
    logic [2:0] code;
    logic acc, fin, rej, err;
    code = 3'd0; acc = 0; fin = 0; rej = 0; err = 0;
    if (to) err = 1;                                      // R11
    else if (pid == P_NYET) begin
      if (last) err = 1; else code = 3'd1;                // R2 / R7
    end else if (pid == P_NAK) begin
      code = 3'd2; rej = (m_held != 0);                   // R3 / R9
    end else if (pid == P_STALL) begin
      code = 3'd4; rej = (m_held != 0);
    end else if (pid == P_D0 || pid == P_D1) begin
      if (!crc) err = 1;
      else if ((pid == P_D1) == m_tog) begin
        code = 3'd0; acc = 1; fin = 1;                    // R4
      end else begin
        code = 3'd2; rej = 1;                             // R5
      end
    end else if (pid == P_MD) begin
      if (!crc || last || m_held != 0) err = 1;           // R7
      else begin code = 3'd1; acc = 1; end                // R6
    end else err = 1;
    if (err) begin
      if (m_err < 3) m_err++;
      code = (m_err >= 3) ? 3'd4 : 3'd3;                  // R8
      rej  = (m_held != 0);                               // R9
    end
    if (acc && !fin) m_held = 1;
    else if (!(code == 3'd1 && !acc)) m_held = 0;
    @(negedge clk);
    rsp_valid = 1; rsp_pid = pid; rsp_crc_ok = crc; rsp_timeout = to; last_cs = last;
    @(negedge clk);
    rsp_valid = 0;
    check(tag, {act_valid, act_code, acc_strobe, acc_final, rej_strobe},
          {1'b1, code, acc, fin, rej});
    @(negedge clk);
    check("R1 idle", {act_valid, act_code, acc_strobe, acc_final, rej_strobe}, 7'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] pids [8];
    pids = '{P_D0, P_D1, P_MD, P_NAK, P_STALL, P_NYET, P_ERR, P_BAD};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset", {act_valid, act_code, acc_strobe, acc_final, rej_strobe}, 7'd0);

    load(1);
    send("R2 nyet", P_NYET, 1, 0, 0);
    send("R6 mdata", P_MD, 1, 0, 0);
    send("R4 data1", P_D1, 1, 0, 1);
    load(0);
    send("R4 data0", P_D0, 1, 0, 0);
    load(1);
    send("R5 mismatch", P_D0, 1, 0, 0);
    load(0);
    send("R6 mdata", P_MD, 1, 0, 0);
    send("R9 err after piece", P_ERR, 1, 0, 0);
    send("R3 nak", P_NAK, 1, 0, 0);
    load(0);
    send("R6 mdata", P_MD, 1, 0, 0);
    send("R7 second mdata", P_MD, 1, 0, 0);
    load(0);
    send("R7 mdata last", P_MD, 1, 0, 1);
    send("R7 nyet last", P_NYET, 1, 0, 1);
    send("R8 third strike", P_D0, 0, 0, 0);
    send("R8 saturate", P_BAD, 1, 0, 0);
    load(0);
    send("R11 timeout", P_D0, 1, 1, 0);
    send("R11 timeout", P_STALL, 1, 1, 0);
    load(1);
    send("R10 cleared", P_ERR, 1, 0, 0);
    send("R6 mdata", P_MD, 1, 0, 0);
    send("R3 stall drops piece", P_STALL, 1, 0, 0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 6) == 0) load(1'($urandom_range(0, 1)));
      send("R7 random", pids[$urandom_range(0, 7)], $urandom_range(0, 9) != 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule